// File: doc/BRIEF.md
# Pipelined Fractional Complex Multiplier

This block multiplies two complex operands, X and Y. Each operand has a 16-bit real part and a 16-bit imaginary part, both two's complement fractions. The sign bit weighs -1 and each lower bit weighs half of the bit above it. The block returns the full-precision complex product as a 32-bit real result and a 32-bit imaginary result, in which the sign bit weighs -2. Four partial products are formed in parallel, so a new multiply can start on every clock.

The X and Y operand registers each have their own load enable. A conjugate request for an operand is captured with that operand's data. Three further stages act on each result: a saturating trap for minus one times minus one in any partial product, optional bias-free rounding of the upper half, and a shift that is applied to both components alike. Both 32-bit results are held in an output register. A 2-bit select chooses, for each component on its own, whether the upper or the lower 16 bits appear on that component's 16-bit port. The asynchronous active-low reset is released inside the block through a two-flop synchroniser.

Top module: `cfrac_mul`

## Requirements
- R1: With conjugation, rounding and shift off, the results are re = Xr*Yr - Xi*Yi and im = Xr*Yi + Xi*Yr, as exact 32-bit fractions. The register values at one rising edge appear at the output register after the second rising edge that follows.
- R2: A new operand pair can be taken on every clock, and back-to-back operations do not disturb one another.
- R3: When en_x is low at an edge, the X register (real part, imaginary part and conj_x) keeps its value, and later results use the held X.
- R4: When en_y is low at an edge, the Y register (real part, imaginary part and conj_y) keeps its value, and later results use the held Y.
- R5: A partial product whose two factors are both -32768 (0x8000) is replaced by 0x3FFFFFFF, the most positive 31-bit fraction. The trap works on the stored, unconjugated operands.
- R6: With conj_x high, the imaginary part of X counts as negated. Then re = Xr*Yr + Xi*Yi and im = Xr*Yi - Xi*Yr.
- R7: With conj_y high, the imaginary part of Y counts as negated. Then re = Xr*Yr + Xi*Yi and im = Xi*Yr - Xr*Yi. With both conj_x and conj_y high, both negations apply.
- R8: With round_en high, bit 16 of each 32-bit sum is forced to 1 before the shift. Bits 15 to 0 are unchanged.
- R9: shift_sel acts on both results alike. Code 00 leaves them unshifted, 01 shifts right by one place with sign extension, 10 shifts right by two places with sign extension, and 11 shifts left by one place, dropping the top bit.
- R10: osel[0] selects out_re (0 = bits 31:16 of the real result, 1 = bits 15:0), and osel[1] selects out_im in the same way for the imaginary result. The select acts on the output register without delay.
- R11: While reset is active, and for two cycles after it is released, every register holds zero, so both outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_x | input | 1 | Load enable for the X register |
| en_y | input | 1 | Load enable for the Y register |
| conj_x | input | 1 | Negate the imaginary part of X, captured with X |
| conj_y | input | 1 | Negate the imaginary part of Y, captured with Y |
| x_re | input | 16 | Real part of X |
| x_im | input | 16 | Imaginary part of X |
| y_re | input | 16 | Real part of Y |
| y_im | input | 16 | Imaginary part of Y |
| round_en | input | 1 | Force bit 16 of both sums |
| shift_sel | input | 2 | Output shift code |
| osel | input | 2 | Half select for each output port |
| out_re | output | 16 | Selected half of the real result |
| out_im | output | 16 | Selected half of the imaginary result |

## Verification
Every ordered combination of seven operand values is streamed, one per clock, under all 32 combinations of the two conjugate flags, the round flag and the shift code. The operand values include both extremes, -1 LSB, +1 LSB and two mid-range values. With -32768 on both factors of a partial product, a trap result is told apart from a wrapped one. Mixed signs expose sign errors in the subtraction and in the conjugate terms. Values near full scale expose a lost carry, a wrong sign extension in the right shifts and a wrong drop of the top bit in the left shift. The load enables drop out on their own irregular patterns, so a stale operand shows up as a mismatch. The half select rotates through all four codes, which checks both halves of both results.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

  typedef enum logic [1:0] {
    SH_NONE = 2'b00,
    SH_R1   = 2'b01,
    SH_R2   = 2'b10,
    SH_L1   = 2'b11
  } shift_e;

  typedef struct packed {
    logic   rnd;
    shift_e sh;
  } post_ctrl_t;

endpackage

// File: rtl/cfm_pprod.sv
module cfm_pprod #(
  parameter int DW = 16,
  localparam int PW = 2 * DW - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  output logic signed [PW-1:0] prod_q
);

  localparam logic signed [DW-1:0] MIN_V  = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [PW-1:0] TRAP_V = {1'b0, {(PW-1){1'b1}}};

  logic signed [PW-1:0] a_ext, b_ext, full, prod_d;
  logic                 both_min;

  always_comb begin
    a_ext    = PW'(a);
    b_ext    = PW'(b);
    full     = a_ext * b_ext;
    both_min = (a == MIN_V) && (b == MIN_V);
    prod_d   = both_min ? TRAP_V : full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod_q <= '0;
    else        prod_q <= prod_d;
  end

  AST_TRAP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(a == MIN_V && b == MIN_V) |-> prod_q == TRAP_V); // R5

endmodule

// File: rtl/cfm_combine.sv
module cfm_combine
  import cfm_pkg::*;
#(
  parameter int DW = 16,
  localparam int PW = 2 * DW - 1,
  localparam int SW = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [PW-1:0] p_rr,
  input  logic signed [PW-1:0] p_ri,
  input  logic signed [PW-1:0] p_ir,
  input  logic signed [PW-1:0] p_ii,
  input  logic                 cjx,
  input  logic                 cjy,
  input  post_ctrl_t           ctrl,
  output logic        [SW-1:0] res_re_q,
  output logic        [SW-1:0] res_im_q
);

  logic signed [SW-1:0] e_rr, e_ri, e_ir, e_ii;
  logic signed [SW-1:0] t_ii, t_ri, t_ir;
  logic signed [SW-1:0] sum_re, sum_im, rd_re, rd_im;
  logic        [SW-1:0] re_d, im_d;

  function automatic logic [SW-1:0] do_shift(input logic signed [SW-1:0] v, input shift_e s);
    case (s)
      SH_R1:   do_shift = v >>> 1;
      SH_R2:   do_shift = v >>> 2;
      SH_L1:   do_shift = v << 1;
      default: do_shift = v;
    endcase
  endfunction

  always_comb begin
    e_rr = $signed({p_rr[PW-1], p_rr});
    e_ri = $signed({p_ri[PW-1], p_ri});
    e_ir = $signed({p_ir[PW-1], p_ir});
    e_ii = $signed({p_ii[PW-1], p_ii});
    t_ii = (cjx ^ cjy) ? -e_ii : e_ii;
    t_ri = cjy ? -e_ri : e_ri;
    t_ir = cjx ? -e_ir : e_ir;
    sum_re = e_rr - t_ii;
    sum_im = t_ri + t_ir;
    rd_re  = sum_re;
    rd_im  = sum_im;
    if (ctrl.rnd) begin
      rd_re[DW] = 1'b1;
      rd_im[DW] = 1'b1;
    end
    re_d = do_shift(rd_re, ctrl.sh);
    im_d = do_shift(rd_im, ctrl.sh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_re_q <= '0;
      res_im_q <= '0;
    end else begin
      res_re_q <= re_d;
      res_im_q <= im_d;
    end
  end

  AST_ROUND_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl.rnd && ctrl.sh == SH_NONE) |-> (res_re_q[DW] && res_im_q[DW])); // R8

  AST_RSHIFT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl.sh == SH_R1) |-> (res_re_q[SW-1] == res_re_q[SW-2]
                                 && res_im_q[SW-1] == res_im_q[SW-2])); // R9

endmodule

// File: rtl/cfrac_mul.sv
module cfrac_mul
  import cfm_pkg::*;
#(
  parameter int DW = 16,
  localparam int PW = 2 * DW - 1,
  localparam int SW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          en_x,
  input  logic          en_y,
  input  logic          conj_x,
  input  logic          conj_y,
  input  logic [DW-1:0] x_re,
  input  logic [DW-1:0] x_im,
  input  logic [DW-1:0] y_re,
  input  logic [DW-1:0] y_im,
  input  logic          round_en,
  input  logic [1:0]    shift_sel,
  input  logic [1:0]    osel,
  output logic [DW-1:0] out_re,
  output logic [DW-1:0] out_im
);

  // reset: asserted asynchronously, released after two clean edges
  logic [1:0] rs_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  // operand stage
  logic signed [DW-1:0] xr_q, xi_q, yr_q, yi_q, xr_d, xi_d, yr_d, yi_d;
  logic                 cx_q, cy_q, cx_d, cy_d;
  post_ctrl_t           c1_q, c1_d, c2_q;
  logic                 cx2_q, cy2_q;

  always_comb begin
    xr_d = xr_q;  xi_d = xi_q;  cx_d = cx_q;
    yr_d = yr_q;  yi_d = yi_q;  cy_d = cy_q;
    if (en_x) begin
      xr_d = $signed(x_re);
      xi_d = $signed(x_im);
      cx_d = conj_x;
    end
    if (en_y) begin
      yr_d = $signed(y_re);
      yi_d = $signed(y_im);
      cy_d = conj_y;
    end
    c1_d.rnd = round_en;
    c1_d.sh  = shift_e'(shift_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xr_q <= '0; xi_q <= '0; cx_q <= 1'b0;
      yr_q <= '0; yi_q <= '0; cy_q <= 1'b0;
      c1_q <= '0; c2_q <= '0;
      cx2_q <= 1'b0; cy2_q <= 1'b0;
    end else begin
      xr_q <= xr_d; xi_q <= xi_d; cx_q <= cx_d;
      yr_q <= yr_d; yi_q <= yi_d; cy_q <= cy_d;
      c1_q <= c1_d; c2_q <= c1_q;
      cx2_q <= cx_q; cy2_q <= cy_q;
    end
  end

  // product stage: index = {x part, y part}, 0 = real, 1 = imaginary
  logic signed [PW-1:0] pp_q [4];

  for (genvar g = 0; g < 4; g++) begin : g_pp
    logic signed [DW-1:0] fa, fb;
    assign fa = (g[1] == 1'b0) ? xr_q : xi_q;
    assign fb = (g[0] == 1'b0) ? yr_q : yi_q;
    cfm_pprod #(.DW(DW)) u_pp (
      .clk    (clk),
      .rst_n  (rst_n),
      .a      (fa),
      .b      (fb),
      .prod_q (pp_q[g])
    );
  end

  logic [SW-1:0] res_re_q, res_im_q;

  cfm_combine #(.DW(DW)) u_comb (
    .clk      (clk),
    .rst_n    (rst_n),
    .p_rr     (pp_q[0]),
    .p_ri     (pp_q[1]),
    .p_ir     (pp_q[2]),
    .p_ii     (pp_q[3]),
    .cjx      (cx2_q),
    .cjy      (cy2_q),
    .ctrl     (c2_q),
    .res_re_q (res_re_q),
    .res_im_q (res_im_q)
  );

  assign out_re = osel[0] ? res_re_q[DW-1:0] : res_re_q[SW-1:DW];
  assign out_im = osel[1] ? res_im_q[DW-1:0] : res_im_q[SW-1:DW];

  AST_X_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_x) |-> ($stable(xr_q) && $stable(xi_q) && $stable(cx_q))); // R3

  AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_y) |-> ($stable(yr_q) && $stable(yi_q) && $stable(cy_q))); // R4

endmodule

// File: tb/cfrac_mul_tb_top.sv
module cfrac_mul_tb_top;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        en_x, en_y, conj_x, conj_y, round_en;
  logic [15:0] x_re, x_im, y_re, y_im;
  logic [1:0]  shift_sel, osel;
  logic [15:0] out_re, out_im;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cfrac_mul dut_i (
    .clk(clk), .rst_ni(rst_ni), .en_x(en_x), .en_y(en_y),
    .conj_x(conj_x), .conj_y(conj_y),
    .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im),
    .round_en(round_en), .shift_sel(shift_sel), .osel(osel),
    .out_re(out_re), .out_im(out_im)
  );

  localparam int NV   = 7;
  localparam int NSET = NV * NV * NV * NV;
  localparam int NTOT = 32 * NSET;

  int vals [NV] = '{-32768, -32767, -9000, -1, 1, 16384, 32767};

  logic [31:0] ex_re [4];
  logic [31:0] ex_im [4];
  string       ex_tag [4];

  int hxr, hxi, hyr, hyi;
  bit hcx, hcy;

  task automatic check16(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic longint ppv(input int a, input int b);
    if (a == -32768 && b == -32768) return 64'sh3FFFFFFF;
    return longint'(a) * longint'(b);
  endfunction

  function automatic logic [31:0] post(input longint s, input bit rnd, input logic [1:0] sh);
    logic signed [31:0] r;
    r = s[31:0];
    if (rnd) r[16] = 1'b1;
    case (sh)
      2'b01:   r = r >>> 1;
      2'b10:   r = r >>> 2;
      2'b11:   r = r << 1;
      default: r = r;
    endcase
    return r;
  endfunction

  initial begin
    en_x = 0; en_y = 0; conj_x = 0; conj_y = 0; round_en = 0;
    x_re = 0; x_im = 0; y_re = 0; y_im = 0; shift_sel = 0; osel = 0;
    hxr = 0; hxi = 0; hyr = 0; hyi = 0; hcx = 0; hcy = 0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    // R11: outputs are zero while reset is held, for every half select
    for (int k = 0; k < 4; k++) begin
      osel = 2'(k);
      #1;
      check16("R11", "out_re in reset", out_re, 16'h0000);
      check16("R11", "out_im in reset", out_im, 16'h0000);
    end
    osel = 0;
    @(negedge clk);
    rst_ni = 1'b1;
    // R11: zero through the two synchroniser cycles
    @(negedge clk);
    check16("R11", "out_re after release", out_re, 16'h0000);
    @(negedge clk);
    check16("R11", "out_im after release", out_im, 16'h0000);
    @(negedge clk);

    for (int t = 0; t < NTOT + 3; t++) begin
      if (t >= 3) begin
        int j;
        j = (t - 3) % 4;
        check16(ex_tag[j], "out_re", out_re,
                osel[0] ? ex_re[j][15:0] : ex_re[j][31:16]);
        check16(ex_tag[j], "out_im", out_im,
                osel[1] ? ex_im[j][15:0] : ex_im[j][31:16]);
      end
      if (t < NTOT) begin
        int m, rest;
        bit cx, cy, rn;
        logic [1:0] sh;
        longint prr, pri, pir, pii, sre, sim;
        string tg;
        bit trap;
        m    = t / NSET;
        rest = t % NSET;
        cy = m[0]; cx = m[1]; rn = m[2]; sh = m[4:3];
        en_x = (t % 11) != 4;
        en_y = (t % 13) != 6;
        x_re = 16'(vals[rest % NV]);
        x_im = 16'(vals[(rest / NV) % NV]);
        y_re = 16'(vals[(rest / (NV * NV)) % NV]);
        y_im = 16'(vals[rest / (NV * NV * NV)]);
        conj_x = cx; conj_y = cy; round_en = rn; shift_sel = sh;
        osel = 2'(t % 4);
        if (en_x) begin
          hxr = int'($signed(x_re)); hxi = int'($signed(x_im)); hcx = cx;
        end
        if (en_y) begin
          hyr = int'($signed(y_re)); hyi = int'($signed(y_im)); hcy = cy;
        end
        prr = ppv(hxr, hyr); pri = ppv(hxr, hyi);
        pir = ppv(hxi, hyr); pii = ppv(hxi, hyi);
        sre = prr - ((hcx ^ hcy) ? -pii : pii);
        sim = (hcy ? -pri : pri) + (hcx ? -pir : pir);
        ex_re[t % 4] = post(sre, rn, sh);
        ex_im[t % 4] = post(sim, rn, sh);
        trap = (hxr == -32768 && (hyr == -32768 || hyi == -32768)) ||
               (hxi == -32768 && (hyr == -32768 || hyi == -32768));
        if (trap)              tg = "R5";
        else if (!en_x)        tg = "R3";
        else if (!en_y)        tg = "R4";
        else if (hcx)          tg = "R6";
        else if (hcy)          tg = "R7";
        else if (rn)           tg = "R8";
        else if (sh != 2'b00)  tg = "R9";
        else if (osel != 2'b00) tg = "R10";
        else if (t % 2 == 1)   tg = "R2";
        else                   tg = "R1";
        ex_tag[t % 4] = tg;
      end
      @(negedge clk);
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R2 actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule